// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the program counter of a small core that executes 12-bit instructions. The clock it receives is the oscillator clock, and four oscillator periods make one instruction cycle. While one instruction executes, the next one is fetched. The block advances the counter once per instruction cycle, on the last of the four phases. The decode logic outside the block supplies a one-hot-free operation code together with an immediate field, a page bit and a data byte.

The counter can step forward, jump, call, return, or have its low byte overwritten. Every operation other than a step redirects the fetch stream. In that case the block raises a flush flag for the whole following instruction cycle, so the instruction already prefetched executes as a bubble. Calls and returns use a hardware return stack with two levels. After reset the fetch address is the top word of memory, which holds a calibration load. Execution then wraps to address zero.

Top module: `pgpc_sequencer`

## Requirements
- R1: While reset is held and right after it is released, the fetch address is all ones (3FFh), the flush flag is 0 and the phase count is 0.
- R2: The phase count runs 0,1,2,3 and repeats. The fetch address and the flush flag change only on the clock edge that ends phase 3. The operation inputs are ignored in phases 0 to 2.
- R3: A step (operation code 0) adds one to the fetch address, and 3FFh wraps to 000h.
- R4: A jump (code 1) sets bits 8..0 of the fetch address to the 9-bit immediate and bit 9 to the page bit.
- R5: A call (code 2) pushes the current fetch address, which is the return point, and loads {page bit, 0, immediate bits 7..0}. Immediate bit 8 is ignored.
- R6: A return (code 3) loads the most recently pushed address and pops it, so two nested calls unwind in last-in, first-out order.
- R7: A third nested call discards the oldest stack entry. A return from an emptied stack reads the deepest entry again.
- R8: A low-byte write (code 4) loads {page bit, 0, data byte}.
- R9: After a jump, call, return or low-byte write, the flush flag is 1 for the whole next instruction cycle. After a step it is 0.
- R10: Operation codes 5, 6 and 7 behave exactly like a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 3 | Operation code, sampled at the end of phase 3 |
| imm_i | input | 9 | Immediate target field |
| page_i | input | 1 | Page bit from the status register |
| wdata_i | input | 8 | Data byte for a low-byte write |
| fetch_addr_o | output | 10 | Address of the instruction being fetched |
| flush_o | output | 1 | Current instruction slot is a bubble |
| phase_o | output | 2 | Phase count within the instruction cycle |

## Verification
A corrupted counter shows up on the fetch address at the first phase-3 edge after the fault. A phase counter that is out of step moves that edge, and the move is visible within four clocks. Stack damage shows up only when a return is executed, so the tests nest calls two and three levels deep and then unwind the stack past its bottom. A flush flag that is wrong or held too long shows up in the phases of the slot right after the redirect.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
  localparam int PC_W  = 10;
  localparam int IMM_W = 9;
  localparam int LOW_W = 8;

  localparam logic [2:0] OP_STEP = 3'd0;
  localparam logic [2:0] OP_JUMP = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_LOWR = 3'd4;

  // sequential successor, wraps at the top of memory
  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  // full-width jump: immediate below, page bit on top
  function automatic logic [PC_W-1:0] f_jump(input logic pg, input logic [IMM_W-1:0] im);
    logic [PC_W-1:0] t;
    t = '0;
    t[IMM_W-1:0] = im;
    t[PC_W-1] = pg;
    return t;
  endfunction

  // low-byte target with bit 8 forced clear; shared by call and low write
  function automatic logic [PC_W-1:0] f_low(input logic pg, input logic [LOW_W-1:0] lo);
    logic [PC_W-1:0] t;
    t = '0;
    t[LOW_W-1:0] = lo;
    t[PC_W-1] = pg;
    return t;
  endfunction
endpackage

// File: rtl/pgpc_phase.sv
module pgpc_phase #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic [$clog2(PHASES)-1:0] phase,
  output logic cyc_end
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  assign cyc_end = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (cyc_end) phase <= '0;
    else phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/pgpc_stack.sv
module pgpc_stack #(
  parameter int DEPTH = 2,
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  logic [W-1:0] ent [DEPTH];

  assign top = ent[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] from_above, from_below;
    if (i == 0) begin : g_first
      assign from_above = din;
    end else begin : g_inner
      assign from_above = ent[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_below = ent[i];   // bottom keeps its value on pop
    end else begin : g_mid
      assign from_below = ent[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[i] <= '0;
      else if (push) ent[i] <= from_above;
      else if (pop) ent[i] <= from_below;
    end
  end
endmodule

// File: rtl/pgpc_next.sv
module pgpc_next
  import pgpc_pkg::*;
(
  input  logic [2:0] op,
  input  logic [PC_W-1:0] pc,
  input  logic [IMM_W-1:0] imm,
  input  logic page,
  input  logic [LOW_W-1:0] wdata,
  input  logic [PC_W-1:0] stk_top,
  output logic [PC_W-1:0] nxt,
  output logic push,
  output logic pop,
  output logic redirect
);
  always_comb begin
    nxt = f_step(pc);
    push = 1'b0;
    pop = 1'b0;
    redirect = 1'b1;
    case (op)
      OP_JUMP: nxt = f_jump(page, imm);
      OP_CALL: begin
        nxt = f_low(page, imm[LOW_W-1:0]);
        push = 1'b1;
      end
      OP_RET: begin
        nxt = stk_top;
        pop = 1'b1;
      end
      OP_LOWR: nxt = f_low(page, wdata);
      default: redirect = 1'b0;
    endcase
  end
endmodule

// File: rtl/pgpc_sequencer.sv
module pgpc_sequencer
  import pgpc_pkg::*;
#(
  parameter int STK_DEPTH = 2,
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [2:0] op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic page_i,
  input  logic [LOW_W-1:0] wdata_i,
  output logic [PC_W-1:0] fetch_addr_o,
  output logic flush_o,
  output logic [$clog2(PHASES)-1:0] phase_o
);
  localparam logic [PC_W-1:0] RESET_VEC = '1;

  logic cyc_end;
  logic [PC_W-1:0] pc_q, pc_nxt, stk_top;
  logic nx_push, nx_pop, redirect;
  logic push, pop;
  logic flush_q;

  pgpc_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase_o), .cyc_end(cyc_end)
  );

  pgpc_next u_next (
    .op(op_i), .pc(pc_q), .imm(imm_i), .page(page_i), .wdata(wdata_i),
    .stk_top(stk_top), .nxt(pc_nxt), .push(nx_push), .pop(nx_pop),
    .redirect(redirect)
  );

  assign push = cyc_end & nx_push;
  assign pop  = cyc_end & nx_pop;

  pgpc_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(pc_q), .top(stk_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
      flush_q <= 1'b0;
    end else if (cyc_end) begin
      pc_q <= pc_nxt;
      flush_q <= redirect;
    end
  end

  assign fetch_addr_o = pc_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/pgpc_sequencer_chk.sv
module pgpc_sequencer_chk
  import pgpc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cyc_end,
  input logic [2:0] op,
  input logic [IMM_W-1:0] imm,
  input logic page,
  input logic [PC_W-1:0] fetch,
  input logic flush,
  input logic push,
  input logic pop,
  input logic redirect
);
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(fetch));
  a_r2_hold_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(flush));
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !cyc_end);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && op == OP_STEP |=> fetch == PC_W'($past(fetch) + 1'b1));
  a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && op == OP_JUMP |=> fetch == {$past(page), $past(imm)});
  a_r5_call: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && op == OP_CALL |=> fetch == {$past(page), 1'b0, $past(imm[LOW_W-1:0])});
  a_r6_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !pop);
  a_r9_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> flush == $past(redirect));
endmodule

bind pgpc_sequencer pgpc_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .op(op_i), .imm(imm_i),
  .page(page_i), .fetch(fetch_addr_o), .flush(flush_o), .push(push),
  .pop(pop), .redirect(redirect)
);

// File: tb/pgpc_sequencer_test.sv
module pgpc_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [8:0] imm = '0;
  logic page = 1'b0;
  logic [7:0] wdata = '0;
  logic [9:0] fetch;
  logic flush;
  logic [1:0] phase;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pgpc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .imm_i(imm), .page_i(page),
    .wdata_i(wdata), .fetch_addr_o(fetch), .flush_o(flush), .phase_o(phase)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // wait for phase 3, apply one operation, return one edge later (phase 0)
  task automatic do_op(input logic [2:0] o, input logic [8:0] im, input logic pg,
                       input logic [7:0] wd);
    while (phase != 2'd3) @(negedge clk);
    op = o; imm = im; page = pg; wdata = wd;
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic t_reset();
    chk("R1 addr", 32'(fetch), 32'h3FF);
    chk("R1 flush", 32'(flush), 0);
    chk("R1 phase", 32'(phase), 0);
  endtask

  task automatic t_wrap();
    do_op(3'd0, 0, 0, 0);
    chk("R3 wrap", 32'(fetch), 32'h000);
    chk("R9 step no flush", 32'(flush), 0);
  endtask

  task automatic t_ignore();
    @(negedge clk);
    chk("R2 phase1", 32'(phase), 1);
    op = 3'd1; imm = 9'h155; page = 1'b1;
    @(negedge clk);
    chk("R2 ignored op", 32'(fetch), 32'h000);
    chk("R2 phase2", 32'(phase), 2);
    op = 3'd0;
    do_op(3'd0, 0, 0, 0);
    chk("R2 step after 4", 32'(fetch), 32'h001);
  endtask

  task automatic t_jump();
    do_op(3'd1, 9'h1AB, 1'b1, 0);
    chk("R4 jump", 32'(fetch), 32'h3AB);
    chk("R9 jump flush", 32'(flush), 1);
    @(negedge clk); @(negedge clk);
    chk("R9 flush held", 32'(flush), 1);
    do_op(3'd0, 0, 0, 0);
    chk("R3 step", 32'(fetch), 32'h3AC);
    chk("R9 flush clears", 32'(flush), 0);
  endtask

  task automatic t_nest2();
    do_op(3'd2, 9'h1C0, 1'b0, 0);
    chk("R5 call bit8 ignored", 32'(fetch), 32'h0C0);
    chk("R9 call flush", 32'(flush), 1);
    do_op(3'd0, 0, 0, 0);
    do_op(3'd2, 9'h010, 1'b1, 0);
    chk("R5 call paged", 32'(fetch), 32'h210);
    do_op(3'd3, 0, 0, 0);
    chk("R6 ret inner", 32'(fetch), 32'h0C1);
    chk("R9 ret flush", 32'(flush), 1);
    do_op(3'd3, 0, 0, 0);
    chk("R6 ret outer", 32'(fetch), 32'h3AC);
  endtask

  task automatic t_nest3();
    do_op(3'd2, 9'h020, 1'b0, 0);
    do_op(3'd2, 9'h040, 1'b0, 0);
    do_op(3'd2, 9'h060, 1'b0, 0);
    chk("R7 third call", 32'(fetch), 32'h060);
    do_op(3'd3, 0, 0, 0);
    chk("R7 ret1", 32'(fetch), 32'h040);
    do_op(3'd3, 0, 0, 0);
    chk("R7 ret2 oldest lost", 32'(fetch), 32'h020);
    do_op(3'd3, 0, 0, 0);
    chk("R7 ret past bottom", 32'(fetch), 32'h020);
  endtask

  task automatic t_lowr();
    do_op(3'd4, 9'h1FF, 1'b1, 8'h7E);
    chk("R8 low write paged", 32'(fetch), 32'h27E);
    chk("R9 low write flush", 32'(flush), 1);
    do_op(3'd4, 0, 1'b0, 8'hFF);
    chk("R8 low write", 32'(fetch), 32'h0FF);
    do_op(3'd0, 0, 0, 0);
    chk("R3 carry into bit8", 32'(fetch), 32'h100);
  endtask

  task automatic t_spare_codes();
    do_op(3'd5, 9'h0AA, 1'b1, 8'h11);
    chk("R10 code5", 32'(fetch), 32'h101);
    chk("R10 code5 no flush", 32'(flush), 0);
    do_op(3'd7, 9'h0AA, 1'b1, 8'h11);
    chk("R10 code7", 32'(fetch), 32'h102);
    do_op(3'd1, 9'h1FF, 1'b1, 0);
    do_op(3'd6, 0, 0, 0);
    chk("R10 code6 wraps R3", 32'(fetch), 32'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_ignore();
    t_jump();
    t_nest2();
    t_nest3();
    t_lowr();
    t_spare_codes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule